// File: doc/BRIEF.md
# Programmable Exposure Pulse Generator

This block drives one exposure-style control pulse for a camera. It has two modes. In free-run mode it repeats a waveform whose period and asserted width are both set in clock cycles. In one-shot mode the period setting is not used. Instead, every rising edge on a chosen external input (trigger or encoder) starts one pulse of the programmed width. The external inputs are asynchronous, so each one passes through its own synchronizer and rising-edge detector. An event that arrives while a one-shot pulse is still asserted is dropped, and a saturating counter records how many events were lost this way.

Several instances can sit on one device. One of them is built as the master and always makes its own timing. Any other instance can be set to copy the master's waveform instead of making its own. Polarity inversion is the last stage of the output path. A follower's own invert setting therefore also applies to the waveform it copies. Inverting changes no timing value.

Top module: `exptime_gen`

## Requirements
- R1: In free-run mode, after synchronous reset is released, the output repeats with period P = max(cfg_period, 2) cycles. Each period starts with the pulse asserted for Wf cycles and leaves it deasserted for the remaining cycles. The first period begins in the first cycle after the first clock edge with reset low.
- R2: In free-run mode the width used is Wf = min(cfg_width, P-1), so every period contains at least one deasserted cycle.
- R3: A change to cfg_period, or to cfg_oneshot, takes effect only at a period boundary. In free-run mode the boundary is the end of the current period. In one-shot mode it is any idle cycle, so a pulse in progress always runs to its full length.
- R4: In one-shot mode, a rising edge on the selected input produces a pulse of cfg_width cycles. The pulse asserts on the third clock edge after the input rises. A width of 0 produces no pulse.
- R5: cfg_src_enc = 0 selects trig_in as the event source and cfg_src_enc = 1 selects enc_in. Edges on the input that is not selected have no effect.
- R6: In one-shot mode, an event that arrives while the pulse is asserted does not restart or lengthen the pulse. Each such event adds one to drop_count, which saturates at its maximum value.
- R7: With cfg_follow = 1 on an instance not built as master, the output is master_wave passed through the invert stage. An instance built as master ignores cfg_follow.
- R8: cfg_invert = 1 inverts the final output without changing its timing. It acts at once, as a purely combinational stage.
- R9: On a clock edge with rst = 1, the internal pulse deasserts and drop_count clears. wave_out then equals cfg_invert while cfg_follow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | PERIOD_W | Free-run period in cycles |
| cfg_width | input | PERIOD_W | Asserted width in cycles |
| cfg_oneshot | input | 1 | 1 = one-shot mode, 0 = free-run mode |
| cfg_src_enc | input | 1 | One-shot event source: 0 = trigger, 1 = encoder |
| cfg_invert | input | 1 | 1 = asserted-low output |
| cfg_follow | input | 1 | 1 = copy master_wave (ignored on a master build) |
| trig_in | input | 1 | Asynchronous trigger input |
| enc_in | input | 1 | Asynchronous encoder pulse input |
| master_wave | input | 1 | Waveform from the master instance |
| wave_out | output | 1 | Final waveform |
| drop_count | output | DROP_W | Saturating count of dropped one-shot events |

## Verification
Free-run mode is tried with a table of period, width and polarity settings. The table covers a normal duty cycle, a width larger than the period, a width of zero, the minimum period and inverted polarity. These separate the period count from the width count and from the clamp. One-shot mode is driven by single edges on each source, with the other source toggled as a distractor, then by a second edge that lands inside a pulse, then by a width of zero. These patterns separate source selection, pulse start latency, the no-retrigger rule and drop counting. Changes to the period and the mode made in the middle of a period or a pulse show whether the update waits for a boundary. The follow and invert cases show the order of the output stages.

// File: rtl/exptime_pkg.sv
package exptime_pkg;
   typedef enum logic {
      SRC_TRIG = 1'b0,
      SRC_ENC  = 1'b1
   } src_e;
endpackage

// File: rtl/exptime_sync.sv
module exptime_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("exptime_sync: STAGES must be at least 2");
   end

   // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synchronized value
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/exptime_core.sv
module exptime_core #(
   parameter int PW = 24,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] cfg_period,
   input  logic [PW-1:0] cfg_width,
   input  logic          cfg_oneshot,
   input  logic          ev,
   output logic          pulse,
   output logic          mode_act,
   output logic [DW-1:0] drop_count
);
   localparam logic [PW-1:0] ONE = PW'(1);
   localparam logic [PW-1:0] TWO = PW'(2);

   logic [PW-1:0] cnt, per_q, wid_q;
   logic [PW-1:0] per_clamp, wid_clamp;
   logic          busy;

   assign per_clamp = (cfg_period < TWO) ? TWO : cfg_period;
   assign wid_clamp = (cfg_width > per_clamp - ONE) ? per_clamp - ONE : cfg_width;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt        <= '0;
         per_q      <= ONE;      // forces a boundary on the first cycle
         wid_q      <= '0;
         mode_act   <= 1'b0;
         busy       <= 1'b0;
         drop_count <= '0;
      end else if (!mode_act) begin
         if (cnt >= per_q - ONE) begin
            cnt      <= '0;
            per_q    <= per_clamp;
            mode_act <= cfg_oneshot;
            wid_q    <= cfg_oneshot ? '0 : wid_clamp;
         end else begin
            cnt <= cnt + ONE;
         end
      end else if (busy) begin
         if (ev && drop_count != '1) drop_count <= drop_count + DW'(1);
         if (cnt >= wid_q - ONE) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + ONE;
         end
      end else begin
         mode_act <= cfg_oneshot;
         per_q    <= per_clamp;
         cnt      <= '0;
         if (!cfg_oneshot) begin
            wid_q <= wid_clamp;
         end else if (ev && cfg_width != '0) begin
            busy  <= 1'b1;
            wid_q <= cfg_width;
         end
      end
   end

   assign pulse = mode_act ? busy : (cnt < wid_q);
endmodule

// File: rtl/exptime_gen.sv
module exptime_gen
   import exptime_pkg::*;
#(
   parameter int PERIOD_W    = 24,
   parameter int DROP_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IS_MASTER   = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic [PERIOD_W-1:0] cfg_width,
   input  logic                cfg_oneshot,
   input  logic                cfg_src_enc,
   input  logic                cfg_invert,
   input  logic                cfg_follow,
   input  logic                trig_in,
   input  logic                enc_in,
   input  logic                master_wave,
   output logic                wave_out,
   output logic [DROP_W-1:0]   drop_count
);
   localparam int N_SRC = 2;

   if (PERIOD_W < 2 || PERIOD_W > 32) begin : g_bad_pw
      $error("exptime_gen: PERIOD_W out of range");
   end
   if (DROP_W < 1) begin : g_bad_dw
      $error("exptime_gen: DROP_W must be positive");
   end

   logic [N_SRC-1:0] ext_in, ev_raw;
   logic             ev_sel, own_pulse, mode_act, sel_wave;

   assign ext_in = {enc_in, trig_in};

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      exptime_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst  (rst),
         .din  (ext_in[g]),
         .rise (ev_raw[g])
      );
   end

   assign ev_sel = (src_e'(cfg_src_enc) == SRC_ENC) ? ev_raw[1] : ev_raw[0];

   exptime_core #(.PW(PERIOD_W), .DW(DROP_W)) u_core (
      .clk         (clk),
      .rst         (rst),
      .cfg_period  (cfg_period),
      .cfg_width   (cfg_width),
      .cfg_oneshot (cfg_oneshot),
      .ev          (ev_sel),
      .pulse       (own_pulse),
      .mode_act    (mode_act),
      .drop_count  (drop_count)
   );

   if (IS_MASTER) begin : g_master
      logic unused_follow;
      assign unused_follow = cfg_follow ^ master_wave;
      assign sel_wave = own_pulse;
   end else begin : g_slave
      assign sel_wave = cfg_follow ? master_wave : own_pulse;
   end

   assign wave_out = sel_wave ^ cfg_invert;
endmodule

// File: rtl/exptime_chk.sv
module exptime_chk #(
   parameter int DROP_W = 8,
   parameter bit IS_MASTER = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_invert,
   input logic              cfg_follow,
   input logic              master_wave,
   input logic              wave_out,
   input logic [DROP_W-1:0] drop_count,
   input logic              own_pulse,
   input logic              mode_act,
   input logic              ev_sel
);
   logic past_rst_q = 1'b0;

   always_ff @(posedge clk) begin
      past_rst_q <= rst;
      if (past_rst_q && (IS_MASTER || !cfg_follow)) begin
         p_reset_idle_r9: assert (wave_out == cfg_invert && drop_count == '0)
            else $error("reset did not idle the output");
      end
   end

   if (!IS_MASTER) begin : g_follow_chk
      p_follow_master_r7: assert property (@(posedge clk) disable iff (rst)
         cfg_follow |-> (wave_out == (master_wave ^ cfg_invert)));
   end

   p_own_polarity_r8: assert property (@(posedge clk) disable iff (rst)
      (IS_MASTER || !cfg_follow) |-> (wave_out == (own_pulse ^ cfg_invert)));

   p_start_needs_event_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_act && $rose(own_pulse)) |-> $past(ev_sel));

   p_drop_on_busy_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_act && own_pulse && ev_sel) |=>
         ((drop_count - $past(drop_count)) == DROP_W'(1) || (&$past(drop_count))));

   p_drop_step_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst) |=> (drop_count == $past(drop_count)
                  || (drop_count - $past(drop_count)) == DROP_W'(1)));
endmodule

bind exptime_gen exptime_chk #(.DROP_W(DROP_W), .IS_MASTER(IS_MASTER)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cfg_invert  (cfg_invert),
   .cfg_follow  (cfg_follow),
   .master_wave (master_wave),
   .wave_out    (wave_out),
   .drop_count  (drop_count),
   .own_pulse   (own_pulse),
   .mode_act    (mode_act),
   .ev_sel      (ev_sel)
);

// File: tb/test_exptime_gen.sv
module test_exptime_gen;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 24;
   localparam int DW = 8;
   localparam int NVEC = 5;
   // period, width, invert
   localparam int TBL [NVEC][3] = '{
      '{5, 2, 0}, '{4, 9, 0}, '{6, 0, 1}, '{3, 1, 1}, '{1, 1, 0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [PW-1:0] cfg_period = '0, cfg_width = '0;
   logic cfg_oneshot = 0, cfg_src_enc = 0, cfg_invert = 0, cfg_follow = 0;
   logic trig_in = 0, enc_in = 0, master_wave = 0;
   logic wave_out;
   logic [DW-1:0] drop_count;
   int checks = 0, failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exptime_gen #(.PERIOD_W(PW), .DROP_W(DW)) i_exptime_gen (
      .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_width(cfg_width),
      .cfg_oneshot(cfg_oneshot), .cfg_src_enc(cfg_src_enc), .cfg_invert(cfg_invert),
      .cfg_follow(cfg_follow), .trig_in(trig_in), .enc_in(enc_in),
      .master_wave(master_wave), .wave_out(wave_out), .drop_count(drop_count)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      int pe, we, inv;
      repeat (3) tick();

      // Free-run table: R1, R2, R8, R9
      for (int i = 0; i < NVEC; i++) begin
         cfg_period = PW'(TBL[i][0]);
         cfg_width  = PW'(TBL[i][1]);
         cfg_invert = TBL[i][2][0];
         inv        = TBL[i][2];
         cfg_oneshot = 0;
         rst = 1;
         tick();
         chk("R9 reset output", int'(wave_out), inv);
         chk("R9 reset drop count", int'(drop_count), 0);
         rst = 0;
         pe = (TBL[i][0] < 2) ? 2 : TBL[i][0];
         we = (TBL[i][1] > pe - 1) ? pe - 1 : TBL[i][1];
         for (int k = 0; k < 2 * pe; k++) begin
            tick();
            chk((TBL[i][1] > pe - 1) ? "R2 clamped width" : "R1 free-run wave",
                int'(wave_out), (((k % pe) < we) ? 1 : 0) ^ inv);
         end
      end

      // R3: period change waits for the boundary
      cfg_invert = 0; cfg_period = 5; cfg_width = 2;
      rst = 1; tick(); rst = 0;
      tick(); tick();                 // k = 0, 1
      cfg_period = 3;
      begin
         int exp_r3 [7] = '{0, 0, 0, 1, 1, 0, 1};
         for (int k = 0; k < 7; k++) begin
            tick();
            chk("R3 period change at boundary", int'(wave_out), exp_r3[k]);
         end
      end

      // R4: one-shot from trigger
      cfg_oneshot = 1; cfg_src_enc = 0; cfg_width = 3; cfg_period = 100;
      rst = 1; tick(); rst = 0; tick(); tick();
      chk("R4 one-shot idle", int'(wave_out), 0);
      trig_in = 1;
      for (int n = 1; n <= 7; n++) begin
         tick();
         chk("R4 one-shot pulse", int'(wave_out), (n >= 3 && n <= 5) ? 1 : 0);
      end
      trig_in = 0; repeat (3) tick();

      // R5: unselected encoder ignored, then selected
      enc_in = 1;
      for (int n = 1; n <= 6; n++) begin
         tick();
         chk("R5 unselected source ignored", int'(wave_out), 0);
      end
      enc_in = 0; repeat (3) tick();
      cfg_src_enc = 1;
      enc_in = 1;
      for (int n = 1; n <= 6; n++) begin
         tick();
         chk("R5 encoder source", int'(wave_out), (n >= 3 && n <= 5) ? 1 : 0);
      end
      enc_in = 0; repeat (3) tick();
      cfg_src_enc = 0;

      // R4: width zero gives no pulse
      cfg_width = 0;
      trig_in = 1;
      for (int n = 1; n <= 6; n++) begin
         tick();
         chk("R4 zero width no pulse", int'(wave_out), 0);
      end
      chk("R4 zero width no drop", int'(drop_count), 0);
      trig_in = 0; repeat (3) tick();

      // R6: second edge inside a pulse is dropped
      cfg_width = 8;
      trig_in = 1;
      for (int n = 1; n <= 11; n++) begin
         tick();
         if (n == 2) trig_in = 0;
         if (n == 4) trig_in = 1;
         if (n == 10) chk("R6 pulse not restarted (last high)", int'(wave_out), 1);
         if (n == 11) chk("R6 pulse not lengthened", int'(wave_out), 0);
      end
      chk("R6 dropped event counted", int'(drop_count), 1);
      trig_in = 0; repeat (4) tick();

      // R3: clearing one-shot during a pulse waits until idle
      cfg_width = 4; cfg_period = 6;
      trig_in = 1;
      for (int n = 1; n <= 8; n++) begin
         tick();
         if (n == 3) begin
            chk("R3 pulse started", int'(wave_out), 1);
            cfg_oneshot = 0;
         end
         if (n >= 4 && n <= 6) chk("R3 pulse completes after mode clear", int'(wave_out), 1);
         if (n == 7) chk("R3 pulse end", int'(wave_out), 0);
         if (n == 8) chk("R3 free-run resumes at idle", int'(wave_out), 1);
      end
      trig_in = 0;

      // R8: invert acts at once; R9: reset mid-pulse
      cfg_invert = 1; #1;
      chk("R8 invert immediate", int'(wave_out), 0);
      rst = 1; tick();
      chk("R9 reset mid-pulse", int'(wave_out), 1);
      chk("R9 drop count cleared", int'(drop_count), 0);
      rst = 0;

      // R7 follow, R8 invert applies to followed wave
      cfg_follow = 1; cfg_invert = 0; master_wave = 1; #1;
      chk("R7 follow master high", int'(wave_out), 1);
      master_wave = 0; #1;
      chk("R7 follow master low", int'(wave_out), 0);
      cfg_invert = 1; #1;
      chk("R8 invert on followed wave", int'(wave_out), 1);
      cfg_follow = 0;
      tick();

      summary();
   end
endmodule